// File: doc/BRIEF.md
# Cross-Bridge Bus Lock Controller

This block tracks exclusive-access locking on both sides of a bridge that joins a primary and a secondary shared parallel bus. Each bus has its own four-state lock tracker. The tracker samples the bus's active-low frame, initiator-ready, target-ready, stop and lock lines. It recognises a lock attempt when a master starts a transaction from an idle bus whose lock line is free. The master keeps lock deasserted in the address phase and asserts it on the following clock. The lock counts as established only when a data transfer with the target completes.

The two trackers run independently, so each bus can hold its own lock at the same time. They are coupled only when a locked transaction crosses the bridge. The originating side flags this with a crossing-request input during the address phase. The bridge then forwards the transaction and drives the lock line on the target bus, following the same initiator rule. The drive is held as long as the originating lock lives. While the bridge holds such a lock, crossing requests raised by other masters on the locked target bus are told to retry.

Top module: `xlock_ctl`

## Requirements
- R1: During and just after reset, both bus states read FREE, and both lock drive enables and both retry outputs are 0.
- R2: Bus states are encoded FREE=0, ADDR=1, PEND=2, HELD=3. A bus's 2-bit state appears in `lk_state` with bus 0 in bits [1:0] and bus 1 in bits [3:2]. From FREE, an address phase (frame low) with lock high moves the bus to ADDR, provided frame, irdy and lock were all high in the preceding cycle. From ADDR, lock low moves the bus to PEND, and lock high returns it to FREE.
- R3: An address phase is not a lock attempt if the previous cycle was not idle or had lock asserted. In that case the state stays FREE.
- R4: From PEND, a cycle with irdy and trdy both low moves the bus to HELD. If lock goes low in the ADDR cycle together with a completed data transfer, the bus moves straight from ADDR to HELD.
- R5: In PEND (or ADDR with lock low), stop low with trdy high, or a return to idle without a data transfer, sends the bus back to FREE.
- R6: A HELD bus returns to FREE only in a cycle where lock is high and the bus is idle (frame and irdy high). Lock high on a busy bus, or an idle bus with lock low, keeps it HELD.
- R7: With no crossing request, both buses can reach HELD at the same time and neither lock drive enable is raised.
- R8: A lock attempt flagged with `xreq` on one bus marks that bus as the origin. The next lock-free address phase on the other bus is the bridge's forwarded one. The lock drive enable for that bus rises in the cycle after that address phase and not during it.
- R9: The lock drive enable on the target bus falls at the same clock edge where the origin bus returns to FREE, whether the origin released the lock or failed to obtain it.
- R10: If the forwarded attempt on the target bus falls back to FREE (for example on a retry), the lock drive enable on that bus falls at the same edge.
- R11: `xretry[k]` is high in the same cycle that `lock_oe[k]`, `xreq[k]` and frame on bus k are all asserted, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus samplers |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 2 | Frame line per bus, active low (bit 0 primary, bit 1 secondary) |
| irdy_n | input | 2 | Initiator-ready per bus, active low |
| trdy_n | input | 2 | Target-ready per bus, active low |
| stop_n | input | 2 | Target stop per bus, active low |
| lock_n | input | 2 | Sampled lock line per bus, active low |
| xreq | input | 2 | Transaction on this bus targets the opposite bus |
| lock_oe | output | 2 | Bridge drives the lock line low on this bus |
| xretry | output | 2 | Answer the current crossing request on this bus with retry |
| lk_state | output | 4 | Lock state per bus, 2 bits each |

## Verification
Bus states and lock drive enables are registered. A stimulus held during one cycle therefore shows in `lk_state` and `lock_oe` in the cycle after the clock edge that samples it. The retry outputs are combinational and are due in the same cycle. The bench changes inputs only after an edge has settled and then waits for the next rising edge plus a fixed offset before it compares registered results. Retry outputs, and the absence of the lock drive during the forwarded address phase, are compared a moment after the inputs change and before that edge. A target bus whose lock is held only by the bridge stays HELD for one more cycle after the origin releases, because the line is seen free only once the enable has dropped. The bench expects that extra cycle.

// File: rtl/xlock_ctl.sv
module xlock_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] frame_n,
  input  logic [1:0] irdy_n,
  input  logic [1:0] trdy_n,
  input  logic [1:0] stop_n,
  input  logic [1:0] lock_n,
  input  logic [1:0] xreq,
  output logic [1:0] lock_oe,
  output logic [1:0] xretry,
  output logic [3:0] lk_state
);

  localparam logic [1:0] FREE = 2'd0;
  localparam logic [1:0] ADDR = 2'd1;
  localparam logic [1:0] PEND = 2'd2;
  localparam logic [1:0] HELD = 2'd3;

  logic [1:0] st_q [2];
  logic [1:0] st_d [2];
  logic [1:0] pfree, xlk, xlk_d, oe_d, xset;
  logic [1:0] start, data, quit;

  assign start = pfree & ~frame_n & lock_n;
  assign data  = ~irdy_n & ~trdy_n;
  assign quit  = (~stop_n & trdy_n) | (frame_n & irdy_n);

  assign xset[0] = (st_q[0] == FREE) & start[0] & xreq[0] & ~xlk[1];
  assign xset[1] = (st_q[1] == FREE) & start[1] & xreq[1] & ~xlk[0] & ~xset[0];

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      st_d[k] = st_q[k];
      case (st_q[k])
        FREE: if (start[k]) st_d[k] = ADDR;
        ADDR: begin
          if (lock_n[k])     st_d[k] = FREE;
          else if (data[k])  st_d[k] = HELD;
          else if (quit[k])  st_d[k] = FREE;
          else               st_d[k] = PEND;
        end
        PEND: begin
          if (data[k])       st_d[k] = HELD;
          else if (quit[k])  st_d[k] = FREE;
        end
        default: if (lock_n[k] && frame_n[k] && irdy_n[k]) st_d[k] = FREE;
      endcase
    end
    for (int k = 0; k < 2; k++)
      xlk_d[k] = (st_d[k] != FREE) && (xlk[k] || xset[k]);
    for (int k = 0; k < 2; k++) begin
      oe_d[k] = lock_oe[k];
      if (!xlk[1-k] || st_d[1-k] == FREE)
        oe_d[k] = 1'b0;
      else if (lock_oe[k] && st_q[k] != FREE && st_d[k] == FREE)
        oe_d[k] = 1'b0;
      else if (!lock_oe[k] && st_q[k] == FREE && start[k])
        oe_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q[0] <= FREE;
      st_q[1] <= FREE;
      pfree   <= 2'b11;
      xlk     <= 2'b00;
      lock_oe <= 2'b00;
    end else begin
      st_q[0] <= st_d[0];
      st_q[1] <= st_d[1];
      pfree   <= frame_n & irdy_n & lock_n;
      xlk     <= xlk_d;
      lock_oe <= oe_d;
    end
  end

  assign xretry   = lock_oe & xreq & ~frame_n;
  assign lk_state = {st_q[1], st_q[0]};

  assert_oe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_oe));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_held_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == HELD && $past(st_q[g]) != HELD) |-> $past(!irdy_n[g] && !trdy_n[g]));
    assert_pend_from_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == PEND && $past(st_q[g]) != PEND) |-> $past(st_q[g]) == ADDR);
    assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q[g]) == HELD && st_q[g] == FREE) |-> $past(lock_n[g] && frame_n[g] && irdy_n[g]));
    assert_oe_after_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_oe[g]) |-> $past(!frame_n[g] && st_q[g] == FREE));
    assert_oe_has_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_oe[g] |-> (xlk[1-g] && st_q[1-g] != FREE));
  end

endmodule

// File: tb/xlock_ctl_test.sv
module xlock_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] f = '0, i = '0, t = '0, s = '0, l = '0, x = '0;
  logic [1:0] frame_n, irdy_n, trdy_n, stop_n, lock_n, xreq;
  logic [1:0] lock_oe, xretry;
  logic [3:0] lk_state;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  assign frame_n = ~f;
  assign irdy_n  = ~i;
  assign trdy_n  = ~t;
  assign stop_n  = ~s;
  assign lock_n  = ~(l | lock_oe);
  assign xreq    = x;

  xlock_ctl uut (.clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .lock_n(lock_n), .xreq(xreq),
    .lock_oe(lock_oe), .xretry(xretry), .lk_state(lk_state));

  task automatic setb(input int k, input logic vf, vi, vt, vs, vl, vx);
    f[k] = vf; i[k] = vi; t[k] = vt; s[k] = vs; l[k] = vl; x[k] = vx;
  endtask

  task automatic tick;
    @(posedge clk); #5;
  endtask

  task automatic chk(input string r, input int a, input int e);
    nchk++;
    if (a != e) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", r, a, e);
    end
  endtask

  function automatic int st(input int k);
    return int'(lk_state[2*k +: 2]);
  endfunction

  task automatic idle_all;
    setb(0, 0, 0, 0, 0, 0, 0); setb(1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    tick;
    chk("R1 state in reset", int'(lk_state), 0);
    chk("R1 oe in reset", int'(lock_oe), 0);
    @(negedge clk); rst_n = 1'b1;
    tick;
    chk("R1 state after reset", int'(lk_state), 0);
    chk("R1 retry after reset", int'(xretry), 0);

    // sweep: bus, second-clock lock, termination (0 data, 1 retry, 2 abort to idle)
    for (int k = 0; k < 2; k++)
      for (int lk2 = 0; lk2 < 2; lk2++)
        for (int term = 0; term < 3; term++) begin
          idle_all; tick;
          setb(k, 1, 0, 0, 0, 0, 0); tick;
          chk("R2 addr", st(k), 1);
          setb(k, 1, 1, 0, 0, lk2[0], 0); tick;
          chk("R2 second clock", st(k), lk2 ? 2 : 0);
          case (term)
            0: setb(k, 1, 1, 1, 0, lk2[0], 0);
            1: setb(k, 1, 1, 0, 1, lk2[0], 0);
            default: setb(k, 0, 0, 0, 0, lk2[0], 0);
          endcase
          tick;
          chk(term == 0 ? "R4 data" : "R5 retry/abort", st(k), (lk2 && term == 0) ? 3 : 0);
          chk("R7 other bus untouched", st(1 - k), 0);
          chk("R7 no oe", int'(lock_oe), 0);
          idle_all; tick;
          chk("R6 release", st(k), 0);
        end

    // R3: lock asserted while idle blocks attempt
    idle_all; setb(0, 0, 0, 0, 0, 1, 0); tick;
    setb(0, 1, 0, 0, 0, 0, 0); tick;
    chk("R3 lock busy before addr", st(0), 0);
    idle_all; tick;

    // R4: direct ADDR to HELD
    setb(0, 1, 0, 0, 0, 0, 0); tick;
    setb(0, 1, 1, 1, 0, 1, 0); tick;
    chk("R4 addr straight to held", st(0), 3);
    // R6 hold cases
    setb(0, 0, 1, 0, 0, 0, 0); tick;
    chk("R6 lock free but busy", st(0), 3);
    setb(0, 0, 0, 0, 0, 1, 0); tick;
    chk("R6 idle but locked", st(0), 3);
    setb(0, 0, 0, 0, 0, 0, 0); tick;
    chk("R6 idle and free", st(0), 0);

    // R5: ADDR with lock low and stop
    setb(1, 1, 0, 0, 0, 0, 0); tick;
    setb(1, 1, 1, 0, 1, 1, 0); tick;
    chk("R5 stop in addr", st(1), 0);
    idle_all; tick;

    // R7: concurrent locks
    setb(0, 1, 0, 0, 0, 0, 0); setb(1, 1, 0, 0, 0, 0, 0); tick;
    setb(0, 1, 1, 0, 0, 1, 0); setb(1, 1, 1, 0, 0, 1, 0); tick;
    setb(0, 1, 1, 1, 0, 1, 0); setb(1, 1, 1, 1, 0, 1, 0); tick;
    chk("R7 both held", int'(lk_state), 15);
    chk("R7 no oe both held", int'(lock_oe), 0);
    idle_all; tick;
    chk("R7 both released", int'(lk_state), 0);

    // R8/R9/R11: bridged lock bus0 -> bus1
    setb(0, 1, 0, 0, 0, 0, 1); tick;
    chk("R8 origin addr", st(0), 1);
    setb(0, 1, 1, 0, 0, 1, 0); tick;
    chk("R8 origin pend", st(0), 2);
    setb(1, 1, 0, 0, 0, 0, 0); #1;
    chk("R8 no oe during addr", int'(lock_oe), 0);
    tick;
    chk("R8 oe after addr", int'(lock_oe), 2);
    chk("R8 target addr", st(1), 1);
    setb(1, 1, 1, 1, 0, 0, 0); tick;
    chk("R8 target held", st(1), 3);
    setb(0, 1, 1, 1, 0, 1, 0); setb(1, 0, 0, 0, 0, 0, 0); tick;
    chk("R8 origin held", st(0), 3);
    chk("R8 target still held", st(1), 3);
    setb(0, 0, 0, 0, 0, 1, 0); setb(1, 1, 0, 0, 0, 0, 1); #1;
    chk("R11 retry on target", int'(xretry), 2);
    tick;
    setb(1, 0, 0, 0, 0, 0, 0); #1;
    chk("R11 retry drops", int'(xretry), 0);
    setb(0, 0, 0, 0, 0, 0, 0); tick;
    chk("R9 origin free", st(0), 0);
    chk("R9 oe dropped", int'(lock_oe), 0);
    chk("R9 target held one more", st(1), 3);
    tick;
    chk("R9 target free", st(1), 0);

    // R10/R9: bridged bus1 -> bus0 with target retry, then origin retry
    setb(1, 1, 0, 0, 0, 0, 1); tick;
    setb(1, 1, 1, 0, 0, 1, 0); tick;
    chk("R10 origin pend", st(1), 2);
    setb(0, 1, 0, 0, 0, 0, 0); tick;
    chk("R10 oe up", int'(lock_oe), 1);
    setb(0, 1, 1, 0, 1, 0, 0); tick;
    chk("R10 target retried", st(0), 0);
    chk("R10 oe dropped", int'(lock_oe), 0);
    chk("R10 origin kept", st(1), 2);
    setb(0, 0, 0, 0, 0, 0, 0); tick;
    setb(0, 1, 0, 0, 0, 0, 0); tick;
    chk("R8 reforward oe", int'(lock_oe), 1);
    setb(1, 1, 1, 0, 1, 1, 0); tick;
    chk("R9 origin retried", st(1), 0);
    chk("R9 oe dropped on failure", int'(lock_oe), 0);
    idle_all; tick;
    chk("R5 target pend to idle", st(0), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule